// File: doc/BRIEF.md
# Signed Divide Unit with Data-Dependent Timing

This unit divides a signed 32-bit dividend by a signed 16-bit divisor and produces a signed 16-bit quotient and remainder. Its busy time follows a fixed timing recipe, so a processor model that uses it stalls for exactly as many clocks as the modelled signed divide instruction would. The recipe depends on the operand signs, on whether the magnitude of the result can fit, and on how many zero bits appear in the upper fifteen bits of the absolute quotient.

Operands are converted to magnitudes at the start. When the upper half of the dividend magnitude is already at least as large as the divisor magnitude, the result cannot fit. The unit flags this case early and finishes after a short fixed time. Otherwise it runs a sixteen-step restoring division on the magnitudes, applies the signs, and pads the remaining time with a countdown so that `done` lands on the exact clock. When a result would leave the signed 16-bit range, the unit reports overflow and keeps the previous outputs unchanged.

The latency L is measured as follows. `start` is sampled high at rising edge k while the unit is idle. `done` is then high during the single cycle that follows edge k+L.

Top module: `divs_timed_unit`

## Requirements
- R1: While reset is held low and after it is released, `busy`, `done`, `ovf`, `quotient` and `remainder` are all zero.
- R2: A `start` seen while idle raises `busy` from the next cycle. `done` is a one-cycle pulse, and `busy` is low in the `done` cycle.
- R3: Absolute overflow is detected when dividend magnitude bits [31:16] are greater than or equal to the divisor magnitude. A zero divisor always falls in this case. Then L is 16 for a non-negative dividend and 18 for a negative one, `ovf` is 1, and `quotient` and `remainder` keep their previous values.
- R4: Without absolute overflow, the base latency is 12. Add 2 if the dividend is negative, then add 110. If the divisor is non-negative, subtract 2 for a non-negative dividend or add 2 for a negative one. A negative divisor makes no sign adjustment.
- R5: On top of the R4 base, each 0 among bits 15 down to 1 of the absolute quotient adds 2 clocks. L therefore lies between 120 and 156.
- R6: On a result that fits, `quotient` is the signed quotient truncated toward zero and `remainder` is the signed remainder, which carries the dividend's sign. Both are two's complement, and `ovf` is 0.
- R7: A result that does not fit the signed 16-bit range is not detected early. It takes the full R4/R5 latency, sets `ovf` to 1 and leaves `quotient` and `remainder` unchanged. The value -32768 counts as fitting.
- R8: A `start` asserted while `busy` is high is ignored. It does not change the running result or its timing, and it produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division with the present operands (honoured only when idle) |
| dividend | input | 32 | Signed dividend, two's complement |
| divisor | input | 16 | Signed divisor, two's complement |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Overflow flag of the last completed division |
| quotient | output | 16 | Signed quotient of the last division that fit |
| remainder | output | 16 | Signed remainder of the last division that fit |

## Verification
The four sign combinations of one small division separate the sign adjustment of the latency from the sign rules of the quotient and remainder. Each case also checks the exact clock count. A second group targets absolute overflow with both dividend signs and with a zero divisor, which pins the 16- and 18-clock early exits and the held outputs. Quotients of 0x8000, 0x7FFF, 0xFFFF and 1 sweep the zero-bit count from its minimum to its maximum. The same cases separate a -32768 result, which fits, from +32768, which does not. A second `start` issued in the middle of a division shows that the running result is not disturbed.

// File: rtl/divs_pkg.sv
package divs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_SETTLE = 2'd2,
        ST_WAIT   = 2'd3
    } divs_state_e;

    localparam int unsigned LAT_START_DEF   = 12;
    localparam int unsigned LAT_NEG_DVD_DEF = 2;
    localparam int unsigned LAT_ABS_OVF_DEF = 4;
    localparam int unsigned LAT_BODY_DEF    = 110;
    localparam int unsigned LAT_SIGN_DEF    = 2;
    localparam int unsigned LAT_ZERO_DEF    = 2;
endpackage

// File: rtl/divs_magnitude.sv
module divs_magnitude #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] value,
    output logic         negative,
    output logic [W-1:0] magnitude
);
    assign negative  = value[W-1];
    assign magnitude = negative ? W'(~value + 1'b1) : value;
endmodule

// File: rtl/divs_step.sv
module divs_step #(
    parameter int unsigned W = 16
) (
    input  logic [W:0]   part,
    input  logic         bit_in,
    input  logic [W-1:0] dvs,
    output logic [W:0]   part_nx,
    output logic         q_bit
);
    logic [W:0] shifted;

    always_comb begin
        shifted = {part[W-1:0], bit_in};
        q_bit   = (shifted >= {1'b0, dvs});
        part_nx = q_bit ? (shifted - {1'b0, dvs}) : shifted;
    end
endmodule

// File: rtl/divs_zero_weight.sv
module divs_zero_weight #(
    parameter int unsigned W        = 16,
    parameter int unsigned LAT_W    = 9,
    parameter int unsigned PER_ZERO = 2
) (
    input  logic [W-1:0]     quot,
    output logic [LAT_W-1:0] extra
);
    always_comb begin
        extra = '0;
        for (int i = 1; i < W; i++) begin
            if (!quot[i]) extra = extra + LAT_W'(PER_ZERO);
        end
    end
endmodule

// File: rtl/divs_timed_unit.sv
module divs_timed_unit
    import divs_pkg::*;
#(
    parameter int unsigned DVS_W       = 16,
    parameter int unsigned LAT_START   = LAT_START_DEF,
    parameter int unsigned LAT_NEG_DVD = LAT_NEG_DVD_DEF,
    parameter int unsigned LAT_ABS_OVF = LAT_ABS_OVF_DEF,
    parameter int unsigned LAT_BODY    = LAT_BODY_DEF,
    parameter int unsigned LAT_SIGN    = LAT_SIGN_DEF,
    parameter int unsigned LAT_ZERO    = LAT_ZERO_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2*DVS_W-1:0]   dividend,
    input  logic [DVS_W-1:0]     divisor,
    output logic                 busy,
    output logic                 done,
    output logic                 ovf,
    output logic [DVS_W-1:0]     quotient,
    output logic [DVS_W-1:0]     remainder
);
    localparam int unsigned DVD_W   = 2 * DVS_W;
    localparam int unsigned STEPS   = DVS_W;
    localparam int unsigned STEP_W  = $clog2(STEPS) + 1;
    localparam int unsigned LAT_MAX = LAT_START + LAT_NEG_DVD + LAT_BODY + LAT_SIGN
                                      + LAT_ZERO * (DVS_W - 1);
    localparam int unsigned LAT_W   = $clog2(LAT_MAX + 1) + 1;

    typedef struct packed {
        divs_state_e          state;
        logic [LAT_W-1:0]     cnt;
        logic [STEP_W-1:0]    step;
        logic [DVS_W:0]       part;
        logic [DVS_W-1:0]     qacc;
        logic [DVS_W-1:0]     dvs;
        logic                 neg_dvd;
        logic                 neg_dvs;
        logic                 pend_ovf;
        logic [DVS_W-1:0]     pend_q;
        logic [DVS_W-1:0]     pend_r;
        logic                 done;
        logic                 ovf;
        logic [DVS_W-1:0]     quot;
        logic [DVS_W-1:0]     remd;
    } divs_regs_t;

    divs_regs_t r_d, r_q;

    logic               dvd_neg, dvs_neg;
    logic [DVD_W-1:0]   dvd_mag;
    logic [DVS_W-1:0]   dvs_mag;
    logic [DVS_W:0]     step_part;
    logic               step_qbit;
    logic [LAT_W-1:0]   zero_extra;
    logic [LAT_W-1:0]   lat_c;
    logic               neg_q_c;
    logic               sgn_ovf_c;

    divs_magnitude #(.W(DVD_W)) u_dvd_mag (
        .value(dividend), .negative(dvd_neg), .magnitude(dvd_mag)
    );

    divs_magnitude #(.W(DVS_W)) u_dvs_mag (
        .value(divisor), .negative(dvs_neg), .magnitude(dvs_mag)
    );

    divs_step #(.W(DVS_W)) u_step (
        .part(r_q.part), .bit_in(r_q.qacc[DVS_W-1]), .dvs(r_q.dvs),
        .part_nx(step_part), .q_bit(step_qbit)
    );

    divs_zero_weight #(.W(DVS_W), .LAT_W(LAT_W), .PER_ZERO(LAT_ZERO)) u_zero (
        .quot(r_q.qacc), .extra(zero_extra)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        lat_c     = LAT_W'(LAT_START) + (dvd_neg ? LAT_W'(LAT_NEG_DVD) : '0);
        neg_q_c   = r_q.neg_dvd ^ r_q.neg_dvs;
        sgn_ovf_c = r_q.qacc[DVS_W-1] && !(neg_q_c && (r_q.qacc[DVS_W-2:0] == '0));

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (dvd_mag[DVD_W-1:DVS_W] >= dvs_mag) begin
                        r_d.cnt      = lat_c + LAT_W'(LAT_ABS_OVF);
                        r_d.pend_ovf = 1'b1;
                        r_d.state    = ST_WAIT;
                    end else begin
                        lat_c = lat_c + LAT_W'(LAT_BODY);
                        if (!dvs_neg) begin
                            lat_c = dvd_neg ? (lat_c + LAT_W'(LAT_SIGN))
                                            : (lat_c - LAT_W'(LAT_SIGN));
                        end
                        r_d.cnt     = lat_c;
                        r_d.part    = {1'b0, dvd_mag[DVD_W-1:DVS_W]};
                        r_d.qacc    = dvd_mag[DVS_W-1:0];
                        r_d.dvs     = dvs_mag;
                        r_d.neg_dvd = dvd_neg;
                        r_d.neg_dvs = dvs_neg;
                        r_d.step    = '0;
                        r_d.state   = ST_DIVIDE;
                    end
                end
            end
            ST_DIVIDE: begin
                r_d.cnt  = r_q.cnt - 1'b1;
                r_d.part = step_part;
                r_d.qacc = {r_q.qacc[DVS_W-2:0], step_qbit};
                r_d.step = r_q.step + 1'b1;
                if (r_q.step == STEP_W'(STEPS - 1)) r_d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                r_d.cnt      = r_q.cnt - 1'b1 + zero_extra;
                r_d.pend_ovf = sgn_ovf_c;
                r_d.pend_q   = neg_q_c ? DVS_W'(~r_q.qacc + 1'b1) : r_q.qacc;
                r_d.pend_r   = r_q.neg_dvd ? DVS_W'(~r_q.part[DVS_W-1:0] + 1'b1)
                                           : r_q.part[DVS_W-1:0];
                r_d.state    = ST_WAIT;
            end
            ST_WAIT: begin
                if (r_q.cnt == LAT_W'(1)) begin
                    r_d.cnt   = '0;
                    r_d.done  = 1'b1;
                    r_d.ovf   = r_q.pend_ovf;
                    if (!r_q.pend_ovf) begin
                        r_d.quot = r_q.pend_q;
                        r_d.remd = r_q.pend_r;
                    end
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
    assign ovf       = r_q.ovf;
    assign quotient  = r_q.quot;
    assign remainder = r_q.remd;
endmodule

// File: rtl/divs_timed_unit_chk.sv
module divs_timed_unit_chk #(
    parameter int unsigned DVS_W   = 16,
    parameter int unsigned MIN_LAT = 120,
    parameter int unsigned MAX_LAT = 156
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic               ovf,
    input logic [DVS_W-1:0]   quotient,
    input logic [DVS_W-1:0]   remainder
);
    logic [15:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    lat_cnt <= '0;
        else if (busy) lat_cnt <= lat_cnt + 1'b1;
        else           lat_cnt <= '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!busy && !done && !ovf) else $error("R1 reset state");
        end
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_abs_ovf_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_cnt < 16'd20) |-> (ovf && (lat_cnt == 16'd16 || lat_cnt == 16'd18)));

    assert_full_lat_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_cnt >= 16'd20) |-> (lat_cnt >= 16'(MIN_LAT) && lat_cnt <= 16'(MAX_LAT)));

    assert_ovf_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> ($stable(quotient) && $stable(remainder)));

    assert_outputs_only_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(ovf)));
endmodule

bind divs_timed_unit divs_timed_unit_chk #(.DVS_W(DVS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ovf(ovf), .quotient(quotient), .remainder(remainder)
);

// File: tb/divs_timed_unit_bench.sv
module divs_timed_unit_bench;
    typedef struct {
        int          acc;
        int          lat;
        bit          ovf;
        logic [15:0] q;
        logic [15:0] r;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, ovf;
    logic [15:0] quotient, remainder;

    int   n_checks = 0;
    int   n_errors = 0;
    int   cyc = 0;
    bit   finished = 1'b0;
    logic [15:0] last_q = '0;
    logic [15:0] last_r = '0;
    exp_t sb[$];

    always #4 clk = ~clk;

    divs_timed_unit u_divs_timed_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .ovf(ovf),
        .quotient(quotient), .remainder(remainder)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    function automatic exp_t model(input logic signed [31:0] a, input logic signed [15:0] b);
        exp_t   e;
        longint ma, mb, aq, sq, sr;
        ma = (a < 0) ? -longint'(a) : longint'(a);
        mb = (b < 0) ? -longint'(b) : longint'(b);
        e.lat = 12 + ((a < 0) ? 2 : 0);
        e.q = last_q;
        e.r = last_r;
        if ((ma >> 16) >= mb) begin
            e.lat += 4;
            e.ovf = 1'b1;
            e.tag = "R3";
            return e;
        end
        e.lat += 110;
        if (b >= 0) e.lat += (a < 0) ? 2 : -2;
        aq = ma / mb;
        for (int i = 1; i < 16; i++) if (((aq >> i) & 1) == 0) e.lat += 2;
        sq = longint'(a) / longint'(b);
        sr = longint'(a) % longint'(b);
        if (sq > 32767 || sq < -32768) begin
            e.ovf = 1'b1;
            e.tag = "R7";
        end else begin
            e.ovf = 1'b0;
            e.q = sq[15:0];
            e.r = sr[15:0];
            e.tag = "R6";
        end
        return e;
    endfunction

    // Driver: pushes the expected item, pulses start, optionally intrudes (R8).
    task automatic run_op(input logic [31:0] a, input logic [15:0] b, input bit intrude);
        exp_t e;
        e = model(a, b);
        e.acc = cyc + 1;
        if (!e.ovf) begin
            last_q = e.q;
            last_r = e.r;
        end
        sb.push_back(e);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        check(busy === 1'b1, "R2 busy after start", busy, 1);
        if (intrude) begin
            repeat (5) @(negedge clk);
            dividend = 32'h0001_0000;
            divisor  = 16'h0001;
            start    = 1'b1;
            @(negedge clk);
            start    = 1'b0;
            dividend = a;
            divisor  = b;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops expected items as the design completes.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc - e.acc == e.lat,
                      (e.tag == "R3") ? "R3 early latency" : "R4 R5 latency",
                      cyc - e.acc, e.lat);
                check(ovf === e.ovf, {e.tag, " ovf flag"}, ovf, e.ovf);
                check(quotient === e.q && remainder === e.r, {e.tag, " quotient/remainder"},
                      {quotient, remainder}, {e.q, e.r});
                check(busy === 1'b0, "R2 idle in done cycle", busy, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(busy === 0 && done === 0 && ovf === 0, "R1 flags in reset", {busy, done, ovf}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(quotient === 0 && remainder === 0, "R1 data after reset", {quotient, remainder}, 0);
        check(busy === 0 && done === 0 && ovf === 0, "R1 flags after reset", {busy, done, ovf}, 0);

        // Sign combinations (R4, R6)
        run_op(32'd100, 16'd7, 1'b0);
        run_op(-32'sd100, 16'd7, 1'b0);
        run_op(32'd100, -16'sd7, 1'b0);
        run_op(-32'sd100, -16'sd7, 1'b0);
        // Absolute overflow (R3): both dividend signs, zero divisor, extreme operands
        run_op(32'h0001_0000, 16'd1, 1'b0);
        run_op(-32'sh0001_0000, 16'd1, 1'b0);
        run_op(32'd5, 16'd0, 1'b0);
        run_op(32'h8000_0000, 16'h8000, 1'b0);
        // Zero-bit count sweep and signed range edges (R5, R7)
        run_op(32'h0000_8000, 16'd1, 1'b0);
        run_op(-32'sd32768, 16'd1, 1'b0);
        run_op(-32'sd1, 16'd1, 1'b0);
        run_op(32'h0000_FFFF, 16'd1, 1'b0);
        run_op(32'h0000_7FFF, 16'd1, 1'b0);
        run_op(32'd123456789, 16'd3000, 1'b0);
        run_op(-32'sd1000000, 16'd77, 1'b0);
        // Start while busy is ignored (R8)
        run_op(32'd100000, -16'sd9, 1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule